// File: doc/BRIEF.md
# GPIO Port Control Registers with Masked Writes

This block is the register file behind one bank of general-purpose pins. The bank is split into ports, four ports of eight pins by default, and each port owns three writable control registers plus a read-only input register. The ownership register decides whether a pin is run by this block or handed to some other on-chip function. The drive-enable register turns the pin into an output. The drive-value register supplies the level the pin drives. The input register shows the synchronised pad level.

Every writable register can also be reached at a second address, a fixed offset above its plain address. A write through that second address carries a per-pin update mask in its upper byte and the new pin values in its lower byte. Only the pins whose mask bit is set change, so software can flip one pin without a read-modify-write sequence and without racing other users of the same port. The bus is a simple single-cycle byte-addressed interface: writes take effect on the clock edge that samples them, and reads are combinational on the address.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every ownership, drive-enable and drive-value bit is 0, so `pad_out`, `pad_oe` and `gpio_own` are all zero and every control register reads as 0.
- R2: A plain write sets a whole register from `bus_wdata[7:0]`. Bits 15:8 are ignored. The register group sits in address bits 5:4 (0 ownership, 1 drive-enable, 2 drive-value, 3 input) and the port sits in bits 3:2, so port registers are 4 bytes apart.
- R3: In a masked write, bit 8+n of `bus_wdata` enables pin n and bit n is its new value. Pins whose enable bit is 0 keep their value. A write with an all-zero mask changes nothing.
- R4: The masked address of each writable register is its plain address plus `MASK_OFS` (0x80 by default).
- R5: `gpio_own` bit 8p+n equals ownership bit n of port p.
- R6: `pad_oe` bit 8p+n is set only when both the ownership bit and the drive-enable bit of that pin are 1. `pad_out` bit 8p+n equals drive-value bit n of port p.
- R7: A read of the input register of port p (address 0x30+4p) returns `pad_in[8p+7:8p]`. The value passes through two flops, so a pad change made before clock edge k shows on reads after edge k+1 and not earlier.
- R8: A write to an input register, to the masked range above the drive-value group, to an address with bits 1:0 not zero, or to any unmapped address changes no register. Reads of such addresses return 0.
- R9: A read of a masked address returns the underlying register in bits 7:0 and 0 in bits 15:8.
- R10: A write changes only the addressed register of the addressed port. All other ports and groups keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 16 | Write data: mask in the upper byte, values in the lower byte |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| pad_in | input | 32 | Pad levels, bit 8p+n is pin n of port p |
| pad_out | output | 32 | Level driven to each pad |
| pad_oe | output | 32 | Drive enable for each pad |
| gpio_own | output | 32 | 1 where the pin is under this block's control |

## Verification
A wrong bit in any control register shows on the pad outputs in the cycle after the write, because those outputs are plain decodes of register state. A mask-merge error therefore shows as a pad that moved when its enable bit was clear, or stayed when it was set. A decode slip shows as a change on a different port or group, or as non-zero upper read bits on a masked address. A wrong synchroniser depth shows only as the input read arriving one cycle early or late, so the input read is sampled in both the cycle before and the cycle after the expected arrival.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

   // register groups, decoded from address bits 5:4
   typedef enum logic [1:0] {
      GRP_OWN  = 2'd0,
      GRP_DRVE = 2'd1,
      GRP_DRVV = 2'd2,
      GRP_PIN  = 2'd3
   } grp_e;

   localparam int unsigned GRP_SPAN    = 16;
   localparam int unsigned BANK_SPAN   = 64;
   localparam int unsigned PORT_STRIDE = 4;
   localparam int unsigned N_CTL_GRPS  = 3;

   typedef struct packed {
      logic       hit;
      logic       masked;
      grp_e       grp;
      logic [1:0] port;
   } dec_t;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
   import gpio_regs_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NUM_PORTS = 4,
   parameter int unsigned MASK_OFS  = 128
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);

   localparam logic [ADDR_W:0]   SPAN_X  = (ADDR_W+1)'(BANK_SPAN);
   localparam logic [ADDR_W:0]   MLO_X   = (ADDR_W+1)'(MASK_OFS);
   localparam logic [ADDR_W:0]   MHI_X   = (ADDR_W+1)'(MASK_OFS + BANK_SPAN);
   localparam logic [ADDR_W-1:0] MOFS_A  = ADDR_W'(MASK_OFS);

   logic [ADDR_W:0]   addr_x;
   logic [ADDR_W-1:0] off;
   logic              plain_hit;
   logic              mask_hit;
   logic              port_ok;
   grp_e              grp;

   always_comb begin
      addr_x    = {1'b0, addr};
      plain_hit = addr_x < SPAN_X;
      mask_hit  = (addr_x >= MLO_X) && (addr_x < MHI_X);
      off       = mask_hit ? (addr - MOFS_A) : addr;
      grp       = grp_e'(off[5:4]);
      port_ok   = 32'(off[3:2]) < NUM_PORTS;
      dec.masked = mask_hit;
      dec.grp    = grp;
      dec.port   = off[3:2];
      dec.hit    = (plain_hit || mask_hit) && (off[1:0] == 2'b00) && port_ok
                   && !(mask_hit && grp == GRP_PIN);
   end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
   import gpio_regs_pkg::*;
#(
   parameter int unsigned PINS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_plain,
   input  logic              wr_mask,
   input  grp_e              grp,
   input  logic [2*PINS-1:0] wdata,
   output logic [PINS-1:0]   own,
   output logic [PINS-1:0]   drve,
   output logic [PINS-1:0]   drvv
);

   logic [PINS-1:0] sel_m;
   logic [PINS-1:0] new_v;

   assign sel_m = wdata[2*PINS-1:PINS];
   assign new_v = wdata[PINS-1:0];

   for (genvar g = 0; g < N_CTL_GRPS; g++) begin : g_reg
      logic [PINS-1:0] q;
      logic            hit;

      assign hit = (grp == grp_e'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_plain && hit)
            q <= new_v;
         else if (wr_mask && hit)
            q <= (q & ~sel_m) | (new_v & sel_m);
      end
   end

   assign own  = g_reg[0].q;
   assign drve = g_reg[1].q;
   assign drvv = g_reg[2].q;

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_regs_pkg::*;
#(
   parameter int unsigned NUM_PORTS     = 4,
   parameter int unsigned PINS_PER_PORT = 8,
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned MASK_OFS      = 128,
   parameter int unsigned SYNC_STAGES   = 2,
   localparam int unsigned NPINS        = NUM_PORTS * PINS_PER_PORT,
   localparam int unsigned DATA_W       = 2 * PINS_PER_PORT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  gpio_own
);

   localparam int unsigned P = PINS_PER_PORT;

   if (NUM_PORTS < 1 || NUM_PORTS > 4) begin : g_bad_ports
      $error("gpio_bank_regs: NUM_PORTS must be 1..4");
   end
   if (ADDR_W < 7) begin : g_bad_aw
      $error("gpio_bank_regs: ADDR_W too small for the map");
   end
   if (MASK_OFS < BANK_SPAN || (MASK_OFS % BANK_SPAN) != 0) begin : g_bad_mofs
      $error("gpio_bank_regs: MASK_OFS must be a multiple of 64, at least 64");
   end
   if (MASK_OFS + BANK_SPAN > (1 << ADDR_W)) begin : g_bad_span
      $error("gpio_bank_regs: masked range does not fit ADDR_W");
   end
   if (P < 1 || P > 16) begin : g_bad_pins
      $error("gpio_bank_regs: PINS_PER_PORT must be 1..16");
   end

   dec_t           dec;
   logic [NPINS-1:0] pin_sync;
   logic [P-1:0]   own_w  [NUM_PORTS];
   logic [P-1:0]   drve_w [NUM_PORTS];
   logic [P-1:0]   drvv_w [NUM_PORTS];

   gpio_addr_dec #(
      .ADDR_W   (ADDR_W),
      .NUM_PORTS(NUM_PORTS),
      .MASK_OFS (MASK_OFS)
   ) u_dec (
      .addr(bus_addr),
      .dec (dec)
   );

   gpio_in_sync #(
      .W     (NPINS),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pad_in),
      .q    (pin_sync)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic sel;
      logic wr_p;
      logic wr_m;

      assign sel  = bus_wr && dec.hit && (dec.port == 2'(p));
      assign wr_p = sel && !dec.masked && (dec.grp != GRP_PIN);
      assign wr_m = sel && dec.masked;

      gpio_port_ctl #(
         .PINS(P)
      ) u_ctl (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_plain(wr_p),
         .wr_mask (wr_m),
         .grp     (dec.grp),
         .wdata   (bus_wdata),
         .own     (own_w[p]),
         .drve    (drve_w[p]),
         .drvv    (drvv_w[p])
      );

      assign pad_out [p*P +: P] = drvv_w[p];
      assign pad_oe  [p*P +: P] = own_w[p] & drve_w[p];
      assign gpio_own[p*P +: P] = own_w[p];
   end

   always_comb begin
      bus_rdata = '0;
      if (dec.hit) begin
         unique case (dec.grp)
            GRP_OWN:  bus_rdata[P-1:0] = own_w [dec.port];
            GRP_DRVE: bus_rdata[P-1:0] = drve_w[dec.port];
            GRP_DRVV: bus_rdata[P-1:0] = drvv_w[dec.port];
            GRP_PIN:  bus_rdata[P-1:0] = pin_sync[32'(dec.port)*P +: P];
         endcase
      end
   end

endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk #(
   parameter int unsigned NUM_PORTS     = 4,
   parameter int unsigned PINS_PER_PORT = 8,
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned MASK_OFS      = 128,
   parameter int unsigned SYNC_STAGES   = 2,
   localparam int unsigned NPINS        = NUM_PORTS * PINS_PER_PORT,
   localparam int unsigned DATA_W       = 2 * PINS_PER_PORT
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [NPINS-1:0]  pad_in,
   input logic [NPINS-1:0]  pad_out,
   input logic [NPINS-1:0]  pad_oe,
   input logic [NPINS-1:0]  gpio_own
);

   localparam int unsigned P = PINS_PER_PORT;

   int unsigned a;
   logic        unaligned;
   logic        port_bad;
   logic        ign_addr;
   logic        ctl_alias;
   logic [1:0]  age;

   assign a         = 32'(bus_addr);
   assign unaligned = bus_addr[1:0] != 2'b00;
   assign port_bad  = ((a >> 2) & 32'd3) >= NUM_PORTS;
   assign ign_addr  = unaligned || port_bad || (a >= 48 && a < MASK_OFS) || (a >= MASK_OFS + 48);
   assign ctl_alias = !unaligned && !port_bad && a >= MASK_OFS && a < MASK_OFS + 48;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   // R1: a reset cycle leaves every pad control at zero
   p_reset_zero_r1: assert property (@(posedge clk)
      !rst_n |=> (pad_out == '0 && pad_oe == '0 && gpio_own == '0));

   // R2: without a write no pad control moves
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(pad_out) && $stable(pad_oe) && $stable(gpio_own)));

   // R3: a masked write with an empty mask changes nothing
   p_empty_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && ctl_alias && bus_wdata[DATA_W-1:P] == '0)
      |=> ($stable(pad_out) && $stable(pad_oe) && $stable(gpio_own)));

   // R8: writes to ignored addresses change nothing
   p_ignored_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && ign_addr) |=> ($stable(pad_out) && $stable(pad_oe) && $stable(gpio_own)));

   // R8: reads of ignored addresses (other than input registers) return zero
   p_ignored_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (unaligned || port_bad || (a >= 64 && a < MASK_OFS) || a >= MASK_OFS + 48)
      |-> bus_rdata == '0);

   // R9: masked reads carry nothing in the upper byte
   p_alias_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_alias |-> bus_rdata[DATA_W-1:P] == '0);

   // R6: a pin is never driven unless the block owns it
   p_oe_owned_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & ~gpio_own) == '0);

   // R7: port 0 input read lags the pad by two edges
   if (SYNC_STAGES == 2) begin : g_sync_chk
      p_in_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (age >= 2'd2 && a == 48) |-> bus_rdata[P-1:0] == $past(pad_in[P-1:0], 2));
   end

endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
   .NUM_PORTS    (NUM_PORTS),
   .PINS_PER_PORT(PINS_PER_PORT),
   .ADDR_W       (ADDR_W),
   .MASK_OFS     (MASK_OFS),
   .SYNC_STAGES  (SYNC_STAGES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .pad_in   (pad_in),
   .pad_out  (pad_out),
   .pad_oe   (pad_oe),
   .gpio_own (gpio_own)
);

// File: tb/sim_gpio_bank_regs.sv
module sim_gpio_bank_regs;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out;
   logic [31:0] pad_oe;
   logic [31:0] gpio_own;

   always #(CLK_P/2) clk = ~clk;

   gpio_bank_regs u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .pad_in   (pad_in),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe),
      .gpio_own (gpio_own)
   );

   // kinds: 0 read data, 1 pad_out, 2 pad_oe, 3 gpio_own
   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [7:0] m_own  [4];
   logic [7:0] m_drve [4];
   logic [7:0] m_drvv [4];

   // monitor: compares queued expectations a quarter period after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_P/4);
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it = q.pop_front();
            case (it.kind)
               0:       got = {16'h0, bus_rdata};
               1:       got = pad_out;
               2:       got = pad_oe;
               default: got = gpio_own;
            endcase
            n_chk++;
            if (got !== it.exp) begin
               n_fail++;
               $display("FAIL %s (kind %0d): got %h expected %h", it.tag, it.kind, got, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog expired, run hung");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   function automatic void push(int kind, logic [31:0] exp, string tag);
      item_t it;
      it.kind = kind;
      it.exp  = exp;
      it.tag  = tag;
      q.push_back(it);
   endfunction

   // bench model of a write, derived from R2/R3/R4/R8
   function automatic void model_write(logic [7:0] ad, logic [15:0] wd);
      int grp;
      int prt;
      bit msk;
      logic [7:0] cur;
      logic [7:0] nxt;
      if (ad[1:0] != 2'b00) return;
      if (ad < 8'h30) msk = 0;
      else if (ad >= 8'h80 && ad < 8'hB0) msk = 1;
      else return;
      grp = int'(ad[5:4]);
      prt = int'(ad[3:2]);
      cur = (grp == 0) ? m_own[prt] : (grp == 1) ? m_drve[prt] : m_drvv[prt];
      nxt = msk ? ((cur & ~wd[15:8]) | (wd[7:0] & wd[15:8])) : wd[7:0];
      if (grp == 0) m_own[prt] = nxt;
      else if (grp == 1) m_drve[prt] = nxt;
      else m_drvv[prt] = nxt;
   endfunction

   function automatic logic [15:0] model_read(int grp, int prt);
      case (grp)
         0:       return {8'h0, m_own[prt]};
         1:       return {8'h0, m_drve[prt]};
         default: return {8'h0, m_drvv[prt]};
      endcase
   endfunction

   task automatic bus_write(logic [7:0] ad, logic [15:0] wd);
      @(negedge clk);
      bus_wr    = 1'b1;
      bus_addr  = ad;
      bus_wdata = wd;
      @(negedge clk);
      bus_wr    = 1'b0;
      model_write(ad, wd);
   endtask

   task automatic expect_rd(logic [7:0] ad, logic [15:0] exp, string tag);
      @(negedge clk);
      bus_addr = ad;
      push(0, {16'h0, exp}, tag);
   endtask

   // R5, R6, R10: pad outputs follow the model for every port
   task automatic check_pads(string tag);
      logic [31:0] eo, eoe, eown;
      for (int p = 0; p < 4; p++) begin
         eo  [p*8 +: 8] = m_drvv[p];
         eoe [p*8 +: 8] = m_own[p] & m_drve[p];
         eown[p*8 +: 8] = m_own[p];
      end
      push(1, eo,   {tag, " pad_out"});
      push(2, eoe,  {tag, " pad_oe"});
      push(3, eown, {tag, " gpio_own"});
   endtask

   task automatic check_regs(string tag);
      for (int g = 0; g < 3; g++) begin
         for (int p = 0; p < 4; p++) begin
            expect_rd(8'((g << 4) | (p << 2)), model_read(g, p), {tag, " plain"});
         end
      end
   endtask

   initial begin
      for (int p = 0; p < 4; p++) begin
         m_own[p] = '0; m_drve[p] = '0; m_drvv[p] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      check_pads("R1 reset");
      check_regs("R1 reset");

      // R2, R5, R10: plain writes, upper byte ignored
      bus_write(8'h00, 16'hFFA5);
      check_pads("R2 R5 R10 own port0");
      expect_rd(8'h00, 16'h00A5, "R2 own port0 readback");
      bus_write(8'h04, 16'h00FF);
      bus_write(8'h14, 16'h3C0F);
      bus_write(8'h24, 16'h0055);
      check_pads("R6 R10 port1 drive");
      expect_rd(8'h14, 16'h000F, "R2 drve port1");
      expect_rd(8'h24, 16'h0055, "R2 drvv port1");

      // R3, R4: masked writes to drive value of port 2
      bus_write(8'hA8, 16'hF0AA);
      expect_rd(8'h28, 16'h00A0, "R3 R4 masked set upper nibble");
      bus_write(8'hA8, 16'h0F05);
      expect_rd(8'h28, 16'h00A5, "R3 masked lower nibble keeps upper");
      check_pads("R3 R10 after masked drvv");
      // masked ownership and enable on port 3
      bus_write(8'h8C, 16'h8181);
      bus_write(8'h9C, 16'h0101);
      bus_write(8'hAC, 16'h01FF);
      check_pads("R4 R6 port3 via masked aliases");
      // empty mask
      bus_write(8'hA8, 16'h00FF);
      expect_rd(8'h28, 16'h00A5, "R3 empty mask no change");
      check_pads("R3 empty mask pads");
      // single-pin clear on port 0 ownership
      bus_write(8'h80, 16'h2000);
      expect_rd(8'h00, 16'h0085, "R3 single pin clear");

      // R9: masked reads
      expect_rd(8'hA8, 16'h00A5, "R9 masked read drvv port2");
      expect_rd(8'h80, 16'h0085, "R9 masked read own port0");
      expect_rd(8'h94, 16'h000F, "R9 masked read drve port1");

      // R7: input synchroniser latency
      @(negedge clk);
      pad_in = 32'h12345678;
      expect_rd(8'h3C, 16'h0000, "R7 port3 input before second edge");
      expect_rd(8'h3C, 16'h0012, "R7 port3 input after second edge");
      expect_rd(8'h30, 16'h0078, "R7 port0 input");
      expect_rd(8'h34, 16'h0056, "R7 port1 input");
      @(negedge clk);
      pad_in = 32'hA5A5A5A5;
      expect_rd(8'h38, 16'h0034, "R7 port2 old value held one edge");
      expect_rd(8'h38, 16'h00A5, "R7 port2 new value");

      // R8: ignored writes and zero reads
      bus_write(8'h30, 16'hFFFF);
      bus_write(8'hB0, 16'hFFFF);
      bus_write(8'h01, 16'hFFFF);
      bus_write(8'h26, 16'hFFFF);
      bus_write(8'h50, 16'hFFFF);
      bus_write(8'hC0, 16'hFFFF);
      check_pads("R8 ignored writes pads");
      check_regs("R8 ignored writes regs");
      expect_rd(8'h30, 16'h00A5, "R8 input register not written");
      expect_rd(8'h01, 16'h0000, "R8 unaligned read zero");
      expect_rd(8'h50, 16'h0000, "R8 unmapped read zero");
      expect_rd(8'hB0, 16'h0000, "R8 masked input region read zero");
      expect_rd(8'hF4, 16'h0000, "R8 high unmapped read zero");

      // R10: full overwrite of one register leaves others alone
      bus_write(8'h18, 16'h00FF);
      check_pads("R10 drve port2 only");
      check_regs("R10 final regs");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule